// File: doc/BRIEF.md
# Receive Frame DMA Sequencer

This block moves each complete received frame out of an on-chip frame store into a circular buffer in host memory. It uses one DMA channel with a request/acknowledge handshake. When the frame store reports a frame that is ready, the sequencer raises its request. It then moves one 16-bit word for every cycle in which the host's acknowledge is low. Each frame goes out as a status word, then a length word, then the payload words.

An optional burst mode splits a long transfer into fixed windows. The request stays high for a set number of cycles and then drops for a short gap. After the gap the transfer carries on from where it stopped. When the last word of a frame has moved, the block does several things:
- It releases the frame back to the store.
- It advances a start-of-frame offset that wraps at either 16 KB or 64 KB.
- It bumps a frame counter and a byte counter, both cleared when read.
- It sets a sticky event flag, which can also drive an interrupt.

A separate counter records frames the receiver had to drop because it had no room for them.

Top module: `rxDmaSeq`

## Requirements
- R1: While `frameReady` is high and the block is idle, `dmaReq` goes high on the next cycle. The acknowledge `dmaAckN` is active low, and a word moves only on a cycle where `dmaReq` is 1 and `dmaAckN` is 0. With the acknowledge held high, `dmaReq` stays up and no word moves.
- R2: The words of a frame appear on `dmaData` in a fixed order: `frameStatus` first, then `frameLen`, then ceil(`frameLen`/2) payload words taken from `frameData`. `dataRd` pulses once for each payload word moved. A length of 0 sends only the two header words.
- R3: With `cfgBurst` = 0, `dmaReq` stays high without a break from its rise until the cycle in which the last word moves.
- R4: With `cfgBurst` = 1, `dmaReq` is high for exactly HI_CYC cycles and then low for exactly LO_CYC cycles, repeating until the frame ends. The final high window may be shorter. No word is lost or repeated across a gap.
- R5: `frameDone` is a one-cycle pulse in the cycle after the last word moves, and `dmaReq` is low during that pulse.
- R6: `sofOffset` resets to 0. After each frame it becomes (old + 4 + 2·ceil(len/2)) mod 16384 when `cfgBigBuf` = 0, or mod 65536 when `cfgBigBuf` = 1.
- R7: `frameCount` carries a 12-bit frame count in bits 11:0, and bits 15:12 are always 0. It increments once per frame. A one-cycle `readFrameCnt` pulse clears it, and a frame finishing in that same cycle leaves it at 1.
- R8: `byteCount` (16 bits, wraps) adds 4 + 2·ceil(len/2) per frame. A one-cycle `readByteCnt` pulse clears it, and a frame finishing in that same cycle leaves it equal to that frame's bytes.
- R9: `eventFlag` becomes 1 on the cycle after `frameDone` and stays set. A `readEvent` pulse clears it, except that a frame finishing in the same cycle keeps it set.
- R10: `irq` is 1 exactly when `eventFlag` is 1 and `cfgIrqEn` is 1.
- R11: `missCount` (MISS_W bits, wraps) adds one for each cycle in which `missPulse` is high. This happens whether or not a frame transfer is running.
- R12: After reset, `dmaReq`, `dataRd`, `frameDone`, `eventFlag` and `irq` are 0, and `sofOffset`, `frameCount`, `byteCount` and `missCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameReady | input | 1 | Frame store holds a complete accepted frame |
| frameStatus | input | DATA_W | Receive status word of the pending frame |
| frameLen | input | LEN_W | Byte length of the pending frame |
| frameData | input | DATA_W | Current payload word from the frame store |
| dataRd | output | 1 | Advance the frame store to the next payload word |
| frameDone | output | 1 | Frame fully moved; its store space may be freed |
| dmaReq | output | 1 | DMA request, active high |
| dmaAckN | input | 1 | DMA acknowledge, active low |
| dmaData | output | DATA_W | Word being moved to host memory |
| cfgBurst | input | 1 | Burst mode: periodic request gaps |
| cfgBigBuf | input | 1 | Host ring size: 0 = 16 KB, 1 = 64 KB |
| cfgIrqEn | input | 1 | Interrupt enable for the frame event |
| readFrameCnt | input | 1 | Host read of frame count (clears it) |
| readByteCnt | input | 1 | Host read of byte count (clears it) |
| readEvent | input | 1 | Host read of event flag (clears it) |
| missPulse | input | 1 | A frame was dropped for lack of space |
| sofOffset | output | 16 | Start-of-frame offset in the host ring |
| frameCount | output | 16 | Frames moved since last read (bits 11:0) |
| byteCount | output | 16 | Bytes moved since last read |
| eventFlag | output | 1 | Sticky frame-moved event |
| irq | output | 1 | Interrupt request |
| missCount | output | MISS_W | Dropped-frame counter |

## Verification
The bench targets these corner cases:
- Odd lengths and a zero length. A wrong rounding would cut off the last payload word or send an extra one, and the word order and byte counts would then disagree.
- Burst windows measured against their exact high and low lengths. A timer that is off by one, or one that restarted the word index after a gap, would show a wrong window length or a repeated payload word.
- Long frames pushed past both ring sizes, to expose an offset that wraps at the wrong size.
- Counter reads placed in the same cycle a frame finishes. A design that let the clear win would lose that frame from the counts.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int unsigned BYTE_W = 16;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_LENGTH = 2'd1,
    SEL_DATA   = 2'd2
  } wordSel_e;

  typedef struct packed {
    logic              done;
    logic [BYTE_W-1:0] byteInc;
  } dpStrobe_t;
endpackage

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl #(
  parameter int LEN_W  = 16,
  parameter int HI_CYC = 560,
  parameter int LO_CYC = 26
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameReady,
  input  logic [LEN_W-1:0]       frameLen,
  input  logic                   cfgBurst,
  input  logic                   dmaAckN,
  output logic                   dmaReq,
  output logic                   dataRd,
  output logic                   frameDone,
  output rxdma_pkg::wordSel_e    wordSel,
  output rxdma_pkg::dpStrobe_t   strobe
);
  import rxdma_pkg::*;

  localparam int IDX_W   = LEN_W + 1;
  localparam int TMR_MAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} state_e;

  state_e           state;
  logic [IDX_W-1:0] wordIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] payWords;
  logic [TMR_W-1:0] tmr;
  logic             inGap;
  logic             move;
  logic             lastMove;

  // ceil(len/2) payload words after the two header words
  assign payWords = IDX_W'(({1'b0, frameLen} + 1'b1) >> 1);

  assign dmaReq   = (state == ST_XFER) && !inGap;
  assign move     = dmaReq && !dmaAckN;
  assign lastMove = move && (wordIdx == lastIdx);
  assign dataRd   = move && (wordIdx >= IDX_W'(2));
  assign frameDone = (state == ST_DONE);

  always_comb begin
    if (wordIdx == '0)             wordSel = SEL_STATUS;
    else if (wordIdx == IDX_W'(1)) wordSel = SEL_LENGTH;
    else                           wordSel = SEL_DATA;
  end

  assign strobe.done    = (state == ST_DONE);
  assign strobe.byteInc = BYTE_W'({lastIdx, 1'b0} + (IDX_W + 1)'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      lastIdx <= '0;
      tmr     <= '0;
      inGap   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frameReady) begin
            state   <= ST_XFER;
            wordIdx <= '0;
            lastIdx <= payWords + IDX_W'(1);
            tmr     <= '0;
            inGap   <= 1'b0;
          end
        end
        ST_XFER: begin
          if (move) wordIdx <= wordIdx + IDX_W'(1);
          if (lastMove) state <= ST_DONE;
          // burst window timer: high phase, then a fixed gap
          if (inGap) begin
            if (tmr == TMR_W'(LO_CYC - 1)) begin
              inGap <= 1'b0;
              tmr   <= '0;
            end else begin
              tmr <= tmr + TMR_W'(1);
            end
          end else if (cfgBurst) begin
            if (tmr == TMR_W'(HI_CYC - 1)) begin
              inGap <= 1'b1;
              tmr   <= '0;
            end else begin
              tmr <= tmr + TMR_W'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: without burst mode the request never breaks mid-frame
  a_r3_req_steady: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !cfgBurst && !lastMove) |=> dmaReq);

  // R5: completion follows the final word
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(lastMove));

  // R5: completion is a single quiet cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!dmaReq && !dataRd));

  // R4: a gap starts only after a full high window in burst mode
  a_r4_gap_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inGap) |-> $past(cfgBurst) && $past(dmaReq));
endmodule

// File: rtl/rxdma_dp.sv
module rxdma_dp #(
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int FRM_W      = 12,
  parameter int MISS_W     = 10,
  parameter int SMALL_LOG2 = 14,
  parameter int BIG_LOG2   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rxdma_pkg::dpStrobe_t  strobe,
  input  rxdma_pkg::wordSel_e   wordSel,
  input  logic [DATA_W-1:0]     frameStatus,
  input  logic [LEN_W-1:0]      frameLen,
  input  logic [DATA_W-1:0]     frameData,
  input  logic                  cfgBigBuf,
  input  logic                  cfgIrqEn,
  input  logic                  readFrameCnt,
  input  logic                  readByteCnt,
  input  logic                  readEvent,
  input  logic                  missPulse,
  output logic [DATA_W-1:0]     dmaData,
  output logic [15:0]           sofOffset,
  output logic [15:0]           frameCount,
  output logic [15:0]           byteCount,
  output logic                  eventFlag,
  output logic                  irq,
  output logic [MISS_W-1:0]     missCount
);
  import rxdma_pkg::*;

  localparam logic [BYTE_W-1:0] SMALL_MASK = BYTE_W'((64'd1 << SMALL_LOG2) - 1);
  localparam logic [BYTE_W-1:0] BIG_MASK   = BYTE_W'((64'd1 << BIG_LOG2) - 1);
  localparam int PAD_W = 16 - FRM_W;

  logic [FRM_W-1:0]  frmCnt;
  logic [BYTE_W-1:0] byteCnt;
  logic [BYTE_W-1:0] sofReg;
  logic [BYTE_W-1:0] sofSum;
  logic [BYTE_W-1:0] incBytes;
  logic [FRM_W-1:0]  incFrm;

  always_comb begin
    unique case (wordSel)
      SEL_STATUS: dmaData = frameStatus;
      SEL_LENGTH: dmaData = DATA_W'(frameLen);
      default:    dmaData = frameData;
    endcase
  end

  assign sofSum   = sofReg + strobe.byteInc;
  assign incBytes = strobe.done ? strobe.byteInc : '0;
  assign incFrm   = FRM_W'(strobe.done);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sofReg    <= '0;
      frmCnt    <= '0;
      byteCnt   <= '0;
      eventFlag <= 1'b0;
      missCount <= '0;
    end else begin
      if (strobe.done)
        sofReg <= sofSum & (cfgBigBuf ? BIG_MASK : SMALL_MASK);
      frmCnt  <= (readFrameCnt ? '0 : frmCnt)  + incFrm;
      byteCnt <= (readByteCnt  ? '0 : byteCnt) + incBytes;
      if (strobe.done)    eventFlag <= 1'b1;
      else if (readEvent) eventFlag <= 1'b0;
      if (missPulse) missCount <= missCount + MISS_W'(1);
    end
  end

  assign sofOffset  = 16'(sofReg);
  assign frameCount = {{PAD_W{1'b0}}, frmCnt};
  assign byteCount  = 16'(byteCnt);
  assign irq        = eventFlag && cfgIrqEn;

  // R6: small ring keeps the offset below its size
  a_r6_small_range: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.done) && !$past(cfgBigBuf)) |-> (sofOffset <= 16'(SMALL_MASK)));

  // R7: a read with no coincident frame leaves zero
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (readFrameCnt && !strobe.done) |=> (frameCount == 16'd0));

  // R8: same rule for the byte counter
  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (readByteCnt && !strobe.done) |=> (byteCount == 16'd0));

  // R9: completion always leaves the event flag set
  a_r9_event_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> eventFlag);

  // R11: each drop pulse advances the counter by one
  a_r11_miss_step: assert property (@(posedge clk) disable iff (!rstN)
    missPulse |=> (missCount == MISS_W'($past(missCount) + 1'b1)));
endmodule

// File: rtl/rxDmaSeq.sv
module rxDmaSeq #(
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int HI_CYC     = 560,
  parameter int LO_CYC     = 26,
  parameter int FRM_W      = 12,
  parameter int MISS_W     = 10,
  parameter int SMALL_LOG2 = 14,
  parameter int BIG_LOG2   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameReady,
  input  logic [DATA_W-1:0] frameStatus,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] frameData,
  output logic              dataRd,
  output logic              frameDone,
  output logic              dmaReq,
  input  logic              dmaAckN,
  output logic [DATA_W-1:0] dmaData,
  input  logic              cfgBurst,
  input  logic              cfgBigBuf,
  input  logic              cfgIrqEn,
  input  logic              readFrameCnt,
  input  logic              readByteCnt,
  input  logic              readEvent,
  input  logic              missPulse,
  output logic [15:0]       sofOffset,
  output logic [15:0]       frameCount,
  output logic [15:0]       byteCount,
  output logic              eventFlag,
  output logic              irq,
  output logic [MISS_W-1:0] missCount
);
  rxdma_pkg::dpStrobe_t strobe;
  rxdma_pkg::wordSel_e  wordSel;

  rxdma_ctrl #(
    .LEN_W (LEN_W),
    .HI_CYC(HI_CYC),
    .LO_CYC(LO_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameReady(frameReady),
    .frameLen  (frameLen),
    .cfgBurst  (cfgBurst),
    .dmaAckN   (dmaAckN),
    .dmaReq    (dmaReq),
    .dataRd    (dataRd),
    .frameDone (frameDone),
    .wordSel   (wordSel),
    .strobe    (strobe)
  );

  rxdma_dp #(
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .FRM_W     (FRM_W),
    .MISS_W    (MISS_W),
    .SMALL_LOG2(SMALL_LOG2),
    .BIG_LOG2  (BIG_LOG2)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wordSel     (wordSel),
    .frameStatus (frameStatus),
    .frameLen    (frameLen),
    .frameData   (frameData),
    .cfgBigBuf   (cfgBigBuf),
    .cfgIrqEn    (cfgIrqEn),
    .readFrameCnt(readFrameCnt),
    .readByteCnt (readByteCnt),
    .readEvent   (readEvent),
    .missPulse   (missPulse),
    .dmaData     (dmaData),
    .sofOffset   (sofOffset),
    .frameCount  (frameCount),
    .byteCount   (byteCount),
    .eventFlag   (eventFlag),
    .irq         (irq),
    .missCount   (missCount)
  );
endmodule

// File: tb/sim_rxDmaSeq.sv
`timescale 1ns/1ps
module sim_rxDmaSeq;
  localparam int HI = 20;
  localparam int LO = 5;
  localparam int MW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameReady = 1'b0;
  logic [15:0] frameStatus = '0;
  logic [15:0] frameLen = '0;
  logic [15:0] frameData;
  logic dataRd, frameDone, dmaReq;
  logic dmaAckN = 1'b1;
  logic [15:0] dmaData;
  logic cfgBurst = 1'b0, cfgBigBuf = 1'b0, cfgIrqEn = 1'b0;
  logic readFrameCnt = 1'b0, readByteCnt = 1'b0, readEvent = 1'b0;
  logic missPulse = 1'b0;
  logic [15:0] sofOffset, frameCount, byteCount;
  logic eventFlag, irq;
  logic [MW-1:0] missCount;

  always #2.5 clk = ~clk;

  rxDmaSeq #(.HI_CYC(HI), .LO_CYC(LO), .MISS_W(MW)) u0 (
    .clk(clk), .rstN(rstN), .frameReady(frameReady), .frameStatus(frameStatus),
    .frameLen(frameLen), .frameData(frameData), .dataRd(dataRd),
    .frameDone(frameDone), .dmaReq(dmaReq), .dmaAckN(dmaAckN), .dmaData(dmaData),
    .cfgBurst(cfgBurst), .cfgBigBuf(cfgBigBuf), .cfgIrqEn(cfgIrqEn),
    .readFrameCnt(readFrameCnt), .readByteCnt(readByteCnt), .readEvent(readEvent),
    .missPulse(missPulse), .sofOffset(sofOffset), .frameCount(frameCount),
    .byteCount(byteCount), .eventFlag(eventFlag), .irq(irq), .missCount(missCount)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ackPct = 70;
  bit missOn = 0;
  int expMiss = 0;
  int expSof = 0, expFrm = 0, expByte = 0;
  logic [15:0] seedW = '0;
  int pIdx = 0;
  bit busy = 0;
  int monIdx = 0, wordErr = 0, burstErr = 0, hiRun = 0, loRun = 0;
  bit seenHi = 0;

  function automatic logic [15:0] payWord(input logic [15:0] s, input int k);
    return s ^ 16'(k * 40503) ^ 16'(k >> 3);
  endfunction

  function automatic int frameBytes(input int len);
    return 2 * (2 + (len + 1) / 2);
  endfunction

  assign frameData = payWord(seedW, pIdx);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (frameDone) pIdx <= 0;
    else if (dataRd) pIdx <= pIdx + 1;
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // stimulus for the acknowledge and drop pulses, plus transfer monitor
  always @(negedge clk) begin
    dmaAckN = !(($urandom % 100) < ackPct);
    missPulse = missOn && (($urandom % 4) == 0);
    if (missPulse) expMiss++;
    #1;
    if (busy) begin
      if (dmaReq && !dmaAckN) begin
        logic [15:0] e;
        if (monIdx == 0) e = frameStatus;
        else if (monIdx == 1) e = frameLen;
        else e = payWord(seedW, monIdx - 2);
        if (dmaData !== e) wordErr++;
        monIdx++;
      end
      if (dmaReq) begin
        if (seenHi && loRun > 0) begin
          if (!cfgBurst || loRun != LO) burstErr++;
          loRun = 0;
        end
        hiRun++; seenHi = 1;
        if (cfgBurst && hiRun > HI) burstErr++;
      end else if (seenHi) begin
        if (hiRun > 0 && cfgBurst && hiRun != HI) burstErr++;
        hiRun = 0;
        loRun++;
      end
    end
  end

  task automatic runFrame(input int len, input bit burst, input bit rdAtDone, input int stall);
    int bytes;
    int saved;
    cfgBurst = burst;
    frameStatus = 16'($urandom);
    frameLen = 16'(len);
    seedW = 16'($urandom);
    monIdx = 0; wordErr = 0; burstErr = 0; hiRun = 0; loRun = 0; seenHi = 0;
    saved = ackPct;
    if (stall > 0) ackPct = 0;
    busy = 1;
    frameReady = 1'b1;
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      #2;
      check(dmaReq === 1'b1 && monIdx == 0, "R1 request held without ack", monIdx, 0);
      ackPct = saved;
    end
    forever begin
      @(negedge clk);
      if (frameDone) break;
    end
    busy = 0;
    frameReady = 1'b0;
    check(dmaReq === 1'b0, "R5 request low during done", dmaReq, 0);
    if (rdAtDone) begin readFrameCnt = 1; readByteCnt = 1; end
    bytes = frameBytes(len);
    expSof = (expSof + bytes) & (cfgBigBuf ? 32'hFFFF : 32'h3FFF);
    if (rdAtDone) begin expFrm = 1; expByte = bytes & 32'hFFFF; end
    else begin expFrm = (expFrm + 1) & 32'hFFF; expByte = (expByte + bytes) & 32'hFFFF; end
    @(negedge clk);
    readFrameCnt = 0; readByteCnt = 0;
    check(monIdx == 2 + (len + 1) / 2 && wordErr == 0, "R2 word order and count", wordErr, 0);
    check(frameDone === 1'b0 && dmaReq === 1'b0, "R5 done is single pulse", frameDone, 0);
    if (burst) check(burstErr == 0 && hiRun <= HI, "R4 burst windows", burstErr, 0);
    else check(burstErr == 0, "R3 continuous request", burstErr, 0);
    check(sofOffset == 16'(expSof), "R6 start offset", sofOffset, expSof);
    check(frameCount == 16'(expFrm), "R7 frame count", frameCount, expFrm);
    check(byteCount == 16'(expByte), "R8 byte count", byteCount, expByte);
    check(eventFlag === 1'b1, "R9 event set", eventFlag, 1);
    check(irq === cfgIrqEn, "R10 interrupt", irq, cfgIrqEn);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(dmaReq === 0 && dataRd === 0 && frameDone === 0, "R12 reset handshake", dmaReq, 0);
    check(sofOffset == 0 && frameCount == 0 && byteCount == 0 && missCount == 0,
          "R12 reset counters", byteCount, 0);
    check(eventFlag === 0 && irq === 0, "R12 reset flags", eventFlag, 0);

    cfgIrqEn = 1;
    runFrame(6, 0, 0, 8);
    readEvent = 1; @(negedge clk); readEvent = 0;
    check(eventFlag === 0 && irq === 0, "R9 event cleared by read", eventFlag, 0);

    cfgIrqEn = 0;
    runFrame(1, 0, 0, 0);
    check(irq === 0 && eventFlag === 1, "R10 masked interrupt", irq, 0);
    runFrame(0, 0, 0, 0);
    runFrame(200, 1, 0, 0);
    ackPct = 100;
    runFrame(131, 1, 1, 0);
    ackPct = 70;

    // plain reads while idle
    readFrameCnt = 1; readByteCnt = 1; @(negedge clk);
    readFrameCnt = 0; readByteCnt = 0; @(negedge clk);
    expFrm = 0; expByte = 0;
    check(frameCount == 0, "R7 cleared by read", frameCount, 0);
    check(byteCount == 0, "R8 cleared by read", byteCount, 0);

    // random mix with drop pulses running
    missOn = 1;
    for (int i = 0; i < 14; i++) begin
      cfgBigBuf = 1'($urandom);
      cfgIrqEn = 1'($urandom);
      ackPct = 40 + ($urandom % 61);
      runFrame($urandom % 600, 1'($urandom), 1'($urandom), 0);
    end
    missOn = 0;
    repeat (3) @(negedge clk);
    check(missCount == MW'(expMiss), "R11 missed frame count", missCount, expMiss % 1024);

    // small ring wrap, then large ring wrap
    ackPct = 85;
    cfgBigBuf = 0;
    for (int i = 0; i < 3; i++) runFrame(8000, 0, 0, 0);
    check(sofOffset < 16'd16384, "R6 small ring bound", sofOffset, expSof);
    cfgBigBuf = 1;
    for (int i = 0; i < 9; i++) runFrame(7999, i[0], 0, 0);

    // drop pulses while idle
    missPulse = 0;
    missOn = 1; repeat (40) @(negedge clk); missOn = 0;
    repeat (3) @(negedge clk);
    check(missCount == MW'(expMiss), "R11 idle drops", missCount, expMiss % 1024);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule